// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the multicycle control core of a small accumulator machine. Every instruction passes through explicit register transfers among a program counter, a memory address register, a memory buffer register and a narrow instruction register. A fetch reads the word addressed by the program counter into the buffer register, copies its control fields into the instruction register, and advances the counter. An optional indirect subcycle replaces the operand address with a pointer read from memory. The execute subcycle then performs a load, store, add, jump or interrupt-enable update.

All traffic uses one memory port. The port has an address, write data, read data, a read strobe, a write strobe and a ready handshake. The block checks for an interrupt only once an instruction has completed. When the request input is high and the enable bit is set, an interrupt subcycle moves the program counter into the buffer register and writes it to the location named by an internal save pointer. The save pointer then steps downward, the enable bit clears, and fetching resumes at a fixed handler address.

The default configuration has 16-bit words and 8-bit addresses. The handler is at 0xC0, the save pointer starts at 0xFF, and execution starts at address 0.

Top module: `ics_sequencer`

## Requirements
- R1: While reset is held, neither strobe is active. In the first cycle after release no strobe is active. In the next cycle a read is issued at address 0, and the accumulator and flagsOut are zero.
- R2: An instruction word has the opcode in bits [15:13]: load 0, store 1, add 2, jump 3, set-enable 4, and any other code does nothing. Bit 12 is the indirect flag and bits [7:0] are the address. Each fetch reads at the program counter, which then advances by one.
- R3: A strobe stays high, with address and write data stable, until the cycle in which memReady is high. Processing waits in that state meanwhile.
- R4: Read and write strobes are never high in the same cycle.
- R5: When the indirect flag is set, a read at the instruction's address field returns a pointer. The low 8 bits of that pointer become the effective address.
- R6: Load places the word at the effective address in the accumulator. Zero (flagsOut bit 0) and sign (bit 2) follow the value; carry (bit 1) and overflow (bit 3) clear.
- R7: Add replaces the accumulator with the 16-bit sum. Carry is the carry out and overflow is two's-complement overflow, with zero and sign taken from the sum.
- R8: Store writes the accumulator at the effective address and leaves the flags unchanged.
- R9: Jump makes the next fetch come from its address field.
- R10: Set-enable copies instruction bit 0 into the enable bit (flagsOut bit 4).
- R11: If irq and the enable bit are both high once an instruction completes, the address of the next instruction is written at the save pointer. The next fetch then comes from 0xC0.
- R12: The save pointer starts at 0xFF and drops by one per interrupt. The enable bit clears on handler entry, so a held irq does not nest.
- R13: With the enable bit clear, irq has no effect on execution or memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request level |
| memReady | input | 1 | Memory completes the current access |
| memRData | input | 16 | Read data, valid with memReady |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memAddr | output | 8 | Access address (memory address register) |
| memWData | output | 16 | Write data (memory buffer register) |
| accOut | output | 16 | Accumulator |
| flagsOut | output | 5 | {enable, overflow, sign, carry, zero} |

## Verification
On every cycle the assertions check the port handshake: strobes are exclusive and held stable until ready. They also check the interrupt gating: a save starts only when the enable bit is set, the enable bit is low after a save, and the handler fetch comes two cycles later. Only the bench's scenarios can show the data results. These are arithmetic flags across a sweep of corner operands at several memory wait lengths, operands reached through indirect pointers, skipped code after a jump, and the saved return addresses. The bench also shows that the save pointer walks downward and that a request is ignored while interrupts are disabled.

// File: rtl/ics_pkg.sv
package icsPkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_JUMP  = 3'd3,
    OP_SETIE = 3'd4
  } opT;

  typedef enum logic [3:0] {
    S_FETCH_ADDR, S_FETCH_RD, S_LOAD_IR, S_DECODE,
    S_IND_ADDR, S_IND_RD,
    S_EXE_ADDR, S_EXE_RD, S_EXE_ALU, S_EXE_WR,
    S_INT_CHECK, S_INT_WR
  } stateT;

  typedef struct packed {
    logic memRd;
    logic memWr;
    logic marFromPc;
    logic marFromMbr;
    logic marFromSp;
    logic mbrFromMem;
    logic mbrFromAcc;
    logic mbrFromPc;
    logic irFromMbr;
    logic pcInc;
    logic pcFromMbr;
    logic pcFromHandler;
    logic accLoad;
    logic accAdd;
    logic spDec;
    logic ieClear;
    logic ieLoad;
  } ctrlT;
endpackage

// File: rtl/ics_datapath.sv
module ics_datapath
  import icsPkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int HANDLER = 'hC0,
  parameter int SAVE_TOP = 'hFF,
  parameter int RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlT          ctrl,
  input  logic [DW-1:0] memRData,
  output logic [AW-1:0] marOut,
  output logic [DW-1:0] mbrOut,
  output logic [OPW-1:0] irOp,
  output logic          irInd,
  output logic          ieBit,
  output logic [DW-1:0] accOut,
  output logic [4:0]    flagsOut
);
  localparam int IND_BIT = DW - OPW - 1;
  localparam int IRW = OPW + 2;
  localparam logic [AW-1:0] HANDLER_A = AW'(HANDLER);
  localparam logic [AW-1:0] SAVE_A = AW'(SAVE_TOP);
  localparam logic [AW-1:0] RESET_A = AW'(RESET_PC);

  logic [AW-1:0] pc, mar, sp;
  logic [DW-1:0] mbr, acc;
  logic [IRW-1:0] ir;   // {opcode, indirect, bit0}
  logic zF, cF, nF, vF, ie;
  logic [DW:0] sumExt;
  logic addOvf;

  assign sumExt = {1'b0, acc} + {1'b0, mbr};
  assign addOvf = (acc[DW-1] == mbr[DW-1]) && (sumExt[DW-1] != acc[DW-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc  <= RESET_A;
      mar <= '0;
      sp  <= SAVE_A;
      mbr <= '0;
      acc <= '0;
      ir  <= '0;
      zF <= 1'b0; cF <= 1'b0; nF <= 1'b0; vF <= 1'b0; ie <= 1'b0;
    end else begin
      if (ctrl.marFromPc)       mar <= pc;
      else if (ctrl.marFromMbr) mar <= mbr[AW-1:0];
      else if (ctrl.marFromSp)  mar <= sp;

      if (ctrl.mbrFromMem)      mbr <= memRData;
      else if (ctrl.mbrFromAcc) mbr <= acc;
      else if (ctrl.mbrFromPc)  mbr <= DW'(pc);

      if (ctrl.irFromMbr) ir <= {mbr[DW-1 -: OPW], mbr[IND_BIT], mbr[0]};

      if (ctrl.pcInc)              pc <= pc + 1'b1;
      else if (ctrl.pcFromMbr)     pc <= mbr[AW-1:0];
      else if (ctrl.pcFromHandler) pc <= HANDLER_A;

      if (ctrl.accLoad) begin
        acc <= mbr;
        zF  <= (mbr == '0);
        nF  <= mbr[DW-1];
        cF  <= 1'b0;
        vF  <= 1'b0;
      end else if (ctrl.accAdd) begin
        acc <= sumExt[DW-1:0];
        zF  <= (sumExt[DW-1:0] == '0);
        nF  <= sumExt[DW-1];
        cF  <= sumExt[DW];
        vF  <= addOvf;
      end

      if (ctrl.spDec) sp <= sp - 1'b1;

      if (ctrl.ieClear)     ie <= 1'b0;
      else if (ctrl.ieLoad) ie <= ir[0];
    end
  end

  assign marOut   = mar;
  assign mbrOut   = mbr;
  assign irOp     = ir[IRW-1 -: OPW];
  assign irInd    = ir[1];
  assign ieBit    = ie;
  assign accOut   = acc;
  assign flagsOut = {ie, vF, nF, cF, zF};
endmodule

// File: rtl/ics_control.sv
module ics_control
  import icsPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           memReady,
  input  logic           irq,
  input  logic [OPW-1:0] irOp,
  input  logic           irInd,
  input  logic           ieBit,
  output ctrlT           ctrl
);
  stateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_FETCH_ADDR;
    else       state <= nextState;
  end

  always_comb begin
    ctrl = '0;
    nextState = state;
    case (state)
      S_FETCH_ADDR: begin
        ctrl.marFromPc = 1'b1;
        nextState = S_FETCH_RD;
      end
      S_FETCH_RD: begin
        ctrl.memRd = 1'b1;
        if (memReady) begin
          ctrl.mbrFromMem = 1'b1;
          ctrl.pcInc = 1'b1;
          nextState = S_LOAD_IR;
        end
      end
      S_LOAD_IR: begin
        ctrl.irFromMbr = 1'b1;
        nextState = S_DECODE;
      end
      S_DECODE: nextState = irInd ? S_IND_ADDR : S_EXE_ADDR;
      S_IND_ADDR: begin
        ctrl.marFromMbr = 1'b1;
        nextState = S_IND_RD;
      end
      S_IND_RD: begin
        ctrl.memRd = 1'b1;
        if (memReady) begin
          ctrl.mbrFromMem = 1'b1;
          nextState = S_EXE_ADDR;
        end
      end
      S_EXE_ADDR: begin
        nextState = S_INT_CHECK;
        case (irOp)
          OP_LOAD, OP_ADD: begin
            ctrl.marFromMbr = 1'b1;
            nextState = S_EXE_RD;
          end
          OP_STORE: begin
            ctrl.marFromMbr = 1'b1;
            ctrl.mbrFromAcc = 1'b1;
            nextState = S_EXE_WR;
          end
          OP_JUMP:  ctrl.pcFromMbr = 1'b1;
          OP_SETIE: ctrl.ieLoad = 1'b1;
          default: ;
        endcase
      end
      S_EXE_RD: begin
        ctrl.memRd = 1'b1;
        if (memReady) begin
          ctrl.mbrFromMem = 1'b1;
          nextState = S_EXE_ALU;
        end
      end
      S_EXE_ALU: begin
        if (irOp == OP_ADD) ctrl.accAdd = 1'b1;
        else                ctrl.accLoad = 1'b1;
        nextState = S_INT_CHECK;
      end
      S_EXE_WR: begin
        ctrl.memWr = 1'b1;
        if (memReady) nextState = S_INT_CHECK;
      end
      S_INT_CHECK: begin
        if (irq && ieBit) begin
          ctrl.mbrFromPc = 1'b1;
          ctrl.marFromSp = 1'b1;
          nextState = S_INT_WR;
        end else begin
          nextState = S_FETCH_ADDR;
        end
      end
      S_INT_WR: begin
        ctrl.memWr = 1'b1;
        if (memReady) begin
          ctrl.pcFromHandler = 1'b1;
          ctrl.spDec = 1'b1;
          ctrl.ieClear = 1'b1;
          nextState = S_FETCH_ADDR;
        end
      end
      default: nextState = S_FETCH_ADDR;
    endcase
  end
endmodule

// File: rtl/ics_sequencer.sv
module ics_sequencer
  import icsPkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int HANDLER = 'hC0,
  parameter int SAVE_TOP = 'hFF,
  parameter int RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          irq,
  input  logic          memReady,
  input  logic [DW-1:0] memRData,
  output logic          memRd,
  output logic          memWr,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWData,
  output logic [DW-1:0] accOut,
  output logic [4:0]    flagsOut
);
  ctrlT ctrl;
  logic [OPW-1:0] irOp;
  logic irInd, ieBit;

  ics_control u_control (
    .clk(clk), .rstN(rstN), .memReady(memReady), .irq(irq),
    .irOp(irOp), .irInd(irInd), .ieBit(ieBit), .ctrl(ctrl)
  );

  ics_datapath #(
    .DW(DW), .AW(AW), .HANDLER(HANDLER), .SAVE_TOP(SAVE_TOP), .RESET_PC(RESET_PC)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .memRData(memRData),
    .marOut(memAddr), .mbrOut(memWData), .irOp(irOp), .irInd(irInd),
    .ieBit(ieBit), .accOut(accOut), .flagsOut(flagsOut)
  );

  assign memRd = ctrl.memRd;
  assign memWr = ctrl.memWr;
endmodule

// File: rtl/ics_checker.sv
module ics_checker #(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int HANDLER = 'hC0
) (
  input logic          clk,
  input logic          rstN,
  input logic          memRd,
  input logic          memWr,
  input logic          memReady,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memWData,
  input logic          takeInt,
  input logic          ieClr,
  input logic          ieBit
);
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  a_r3_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memReady) |=> (memRd && $stable(memAddr)));

  a_r3_write_held: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !memReady) |=> (memWr && $stable(memAddr) && $stable(memWData)));

  a_r11_save_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    takeInt |-> ieBit);

  a_r12_enable_dropped: assert property (@(posedge clk) disable iff (!rstN)
    ieClr |=> !ieBit);

  a_r11_handler_fetch: assert property (@(posedge clk) disable iff (!rstN)
    ieClr |-> ##2 (memRd && memAddr == AW'(HANDLER)));
endmodule

bind ics_sequencer ics_checker #(.DW(DW), .AW(AW), .HANDLER(HANDLER)) chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr), .memReady(memReady),
  .memAddr(memAddr), .memWData(memWData), .takeInt(ctrl.mbrFromPc),
  .ieClr(ctrl.ieClear), .ieBit(flagsOut[4])
);

// File: tb/ics_sequencer_test.sv
`timescale 1ns/1ps
module ics_sequencer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irq = 1'b0;
  logic memReady;
  logic [15:0] memRData;
  logic memRd, memWr;
  logic [7:0] memAddr;
  logic [15:0] memWData, accOut;
  logic [4:0] flagsOut;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int waitCfg = 0;
  logic [3:0] waitCnt;
  logic [15:0] mem [256];
  logic [4:0] capFlags;
  logic [7:0] saveAddr [8];
  logic [15:0] saveData [8];
  int saveCnt;

  always #2.5 clk = ~clk;

  ics_sequencer uut (
    .clk(clk), .rstN(rstN), .irq(irq), .memReady(memReady), .memRData(memRData),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memWData(memWData),
    .accOut(accOut), .flagsOut(flagsOut)
  );

  // memory model with configurable wait length
  assign memReady = (memRd || memWr) && (int'(waitCnt) >= waitCfg);
  assign memRData = mem[memAddr];

  always @(posedge clk) begin
    if (!rstN || memReady || !(memRd || memWr)) waitCnt <= '0;
    else waitCnt <= waitCnt + 1'b1;
    if (memWr && memReady) begin
      mem[memAddr] <= memWData;
      if (memAddr == 8'h50) capFlags <= flagsOut;
    end
    if (!rstN) saveCnt <= 0;
    else if (memWr && memReady && memAddr >= 8'hF0 && saveCnt < 8) begin
      saveAddr[saveCnt] <= memAddr;
      saveData[saveCnt] <= memWData;
      saveCnt <= saveCnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish act=%0d exp<=180000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(int op, bit ind, int addr);
    return {3'(op), ind, 4'b0000, 8'(addr)};
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hA5A5;
  endtask

  task automatic startRun();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  logic [15:0] vals [6];

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

    // R1: reset behaviour
    clearMem();
    mem[0] = ins(3, 0, 0);
    waitCfg = 0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 strobes in reset", {30'd0, memRd, memWr}, 32'd0);
    rstN = 1'b1;
    #1;
    check("R1 no strobe first cycle", {30'd0, memRd, memWr}, 32'd0);
    @(negedge clk);
    check("R1 first read", {23'd0, memRd, memAddr}, {23'd0, 1'b1, 8'h00});
    check("R1 acc and flags", {11'd0, flagsOut, accOut}, 32'd0);

    // R2..R9, R13: operand sweep at several wait lengths
    for (int w = 0; w < 3; w++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          logic [15:0] a, b, c;
          logic [16:0] s;
          logic ez, ec, en, ev;
          a = vals[i]; b = vals[j]; c = a ^ b;
          s = {1'b0, a} + {1'b0, b};
          ez = (s[15:0] == 16'h0); ec = s[16]; en = s[15];
          ev = (a[15] == b[15]) && (s[15] != a[15]);
          clearMem();
          mem[0] = ins(0, 0, 8'h40);
          mem[1] = ins(2, 0, 8'h41);
          mem[2] = ins(1, 0, 8'h50);
          mem[3] = ins(0, 1, 8'h42);
          mem[4] = ins(1, 1, 8'h44);
          mem[5] = ins(3, 0, 8'h08);
          mem[6] = ins(1, 0, 8'h52);
          mem[8] = ins(3, 0, 8'h08);
          mem[8'h40] = a; mem[8'h41] = b;
          mem[8'h42] = 16'h0043; mem[8'h43] = c;
          mem[8'h44] = 16'h0051;
          waitCfg = (w == 2) ? 3 : w;
          irq = (w == 1);
          startRun();
          repeat (220) @(negedge clk);
          check("R7 R8 R3 sum stored", {16'd0, mem[8'h50]}, {16'd0, s[15:0]});
          check("R7 R8 add flags at store", {27'd0, capFlags}, {27'd0, 1'b0, ev, en, ec, ez});
          check("R5 R8 indirect store of indirect load", {16'd0, mem[8'h51]}, {16'd0, c});
          check("R9 jump skipped store", {16'd0, mem[8'h52]}, 32'h0000A5A5);
          check("R6 R2 final acc", {16'd0, accOut}, {16'd0, c});
          check("R6 load flags", {27'd0, flagsOut}, {27'd0, 1'b0, 1'b0, c[15], 1'b0, (c == 16'h0)});
          check("R13 no save while disabled", saveCnt, 0);
          check("R13 save slot untouched", {16'd0, mem[8'hFF]}, 32'h0000A5A5);
        end
      end
    end
    irq = 1'b0;

    // R10 R11 R12: single interrupt, held request does not nest
    clearMem();
    mem[0] = ins(4, 0, 1);
    mem[1] = ins(0, 0, 8'h40);
    mem[2] = ins(3, 0, 8'h02);
    mem[8'hC0] = ins(0, 0, 8'h41);
    mem[8'hC1] = ins(1, 0, 8'h60);
    mem[8'hC2] = ins(3, 0, 8'hC2);
    mem[8'h40] = 16'h1111; mem[8'h41] = 16'h2222;
    waitCfg = 2;
    irq = 1'b1;
    startRun();
    repeat (300) @(negedge clk);
    check("R11 return address saved", {16'd0, mem[8'hFF]}, 32'h00000001);
    check("R11 handler ran", {16'd0, mem[8'h60]}, 32'h00002222);
    check("R11 handler acc", {16'd0, accOut}, 32'h00002222);
    check("R12 no nested save", saveCnt, 1);
    check("R12 enable cleared", {31'd0, flagsOut[4]}, 32'd0);
    irq = 1'b0;

    // R10 R12: repeated interrupts walk the save pointer downward
    clearMem();
    mem[0] = ins(4, 0, 1);
    mem[1] = ins(3, 0, 8'h01);
    mem[8'hC0] = ins(4, 0, 1);
    mem[8'hC1] = ins(3, 0, 8'hC1);
    waitCfg = 1;
    irq = 1'b1;
    startRun();
    for (int k = 0; k < 800 && saveCnt < 3; k++) @(negedge clk);
    irq = 1'b0;
    repeat (200) @(negedge clk);
    check("R12 three saves", saveCnt, 3);
    check("R12 first slot", {8'd0, saveAddr[0], saveData[0]}, {8'd0, 8'hFF, 16'h0001});
    check("R12 second slot", {8'd0, saveAddr[1], saveData[1]}, {8'd0, 8'hFE, 16'h00C1});
    check("R12 third slot", {8'd0, saveAddr[2], saveData[2]}, {8'd0, 8'hFD, 16'h00C1});
    check("R10 enable set by handler", {31'd0, flagsOut[4]}, 32'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule